// File: doc/BRIEF.md
# Cascaded RGB LED Pixel Node

This block models one element of a daisy chain of addressable colour LEDs. A single data wire carries a stream of pulse-width-coded bits: every bit cell opens with a high phase and closes with a low phase, and a long high phase means 1 while a short one means 0. The node takes the first pixel word that reaches it after a line reset and holds it in a shadow register. Every later bit of the same frame is sent on to the next element on `dout`. Each forwarded bit is rebuilt with clean nominal high times and is not a copy of the incoming waveform.

A low level on the input that lasts `RESET_CYC` clock cycles ends the frame. At that point the shadow register is copied to the colour outputs, and the node is armed to take a new first word. The displayed colour therefore changes only at frame boundaries and never partway through a frame. A parameter selects one of two word layouts: a three-component word of 24 bits in green, red, blue order, or a four-component word of 32 bits in red, green, blue, white order.

Top module: `pixel_chain_node`

## Requirements
- R1: After reset (`rst_n` low), `col_r`, `col_g`, `col_b` and `col_w` are 0 and `dout` is low.
- R2: With `WHITE_EN`=0, the first 24 bits after a line reset are taken most significant bit first. Bits 23..16 are green, 15..8 are red and 7..0 are blue, where bit 23 is the first bit on the wire.
- R3: The colour outputs change only when a low level of `RESET_CYC` cycles is detected. Low gaps shorter than that within a frame commit nothing.
- R4: The first word of a frame is not forwarded. Every bit that follows it in the same frame appears on `dout` as one pulse, in arrival order.
- R5: A forwarded 0 is a `dout` high pulse of exactly `T0H_CYC` cycles. A forwarded 1 is a high pulse of exactly `T1H_CYC` cycles.
- R6: A bit is 1 when the synchronised input is still high `SAMPLE_CYC` cycles after its rising edge. Otherwise it is 0.
- R7: If a line reset arrives before a complete word has been taken, the colour outputs keep their previous values.
- R8: After each line reset, capture starts again. The first word of the next frame is taken and displayed, and nothing from that word is forwarded.
- R9: With `WHITE_EN`=1, the word is 32 bits: bits 31..24 are red, 23..16 green, 15..8 blue and 7..0 white. Bits after these 32 are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial pulse-width-coded data from upstream |
| dout | output | 1 | Regenerated serial data to the next element |
| col_r | output | 8 | Displayed red level |
| col_g | output | 8 | Displayed green level |
| col_b | output | 8 | Displayed blue level |
| col_w | output | 8 | Displayed white level (0 when `WHITE_EN`=0) |

## Verification
The bench sends frames whose first word has distinct component values, so a design that swapped the green and red fields or shifted least significant bit first would show the wrong colour. It holds a long low gap in the middle of a word that is still shorter than the reset length. A design that committed early, or restarted its bit count at that gap, would tear the colour or lose the word. A truncated frame followed by a full frame checks that a partial word never reaches the outputs and that capture re-arms; forwarding the first word or dropping a later bit would show up in the forwarded bit list. It also measures each forwarded high pulse and uses input pulses close to the sample point on either side, which catches copied waveforms and a misplaced sampling instant.

// File: rtl/pixel_chain_pkg.sv
package pixel_chain_pkg;
   // Number of bits in one pixel word for a given variant
   function automatic int unsigned word_bits(input int unsigned comp_w,
                                             input bit white_en);
      return comp_w * (white_en ? 4 : 3);
   endfunction
endpackage

// File: rtl/pxn_bit_slicer.sv
module pxn_bit_slicer #(
   parameter int unsigned SAMPLE_CYC = 11,
   parameter int unsigned RESET_CYC  = 1000,
   parameter int unsigned SYNC_STG   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic bit_vld,
   output logic bit_val,
   output logic line_rst
);
   localparam int unsigned HW = $clog2(SAMPLE_CYC + 1);
   localparam int unsigned LW = $clog2(RESET_CYC + 1);

   logic [SYNC_STG:0] sync_q;
   logic              lvl, rise;
   logic [HW-1:0]     hcnt;
   logic              armed;
   logic [LW-1:0]     lcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STG-1:0], din};
   end

   assign lvl  = sync_q[SYNC_STG-1];
   assign rise = sync_q[SYNC_STG-1] & ~sync_q[SYNC_STG];

   // Sample point after each rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         hcnt    <= '0;
         bit_vld <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_vld <= 1'b0;
         if (rise) begin
            armed <= 1'b1;
            hcnt  <= HW'(1);
         end else if (armed) begin
            if (hcnt == HW'(SAMPLE_CYC)) begin
               armed   <= 1'b0;
               bit_vld <= 1'b1;
               bit_val <= lvl;
            end else begin
               hcnt <= hcnt + HW'(1);
            end
         end
      end
   end

   // Long-low detection, one pulse per low period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt     <= '0;
         line_rst <= 1'b0;
      end else begin
         line_rst <= 1'b0;
         if (lvl) begin
            lcnt <= '0;
         end else if (lcnt != LW'(RESET_CYC)) begin
            lcnt <= lcnt + LW'(1);
            if (lcnt == LW'(RESET_CYC - 1)) line_rst <= 1'b1;
         end
      end
   end

   assert_single_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_rst |=> !line_rst);
   assert_no_bit_at_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> !line_rst);
endmodule

// File: rtl/pxn_word_capture.sv
module pxn_word_capture
   import pixel_chain_pkg::*;
#(
   parameter int unsigned COMP_W   = 8,
   parameter bit          WHITE_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              line_rst,
   output logic              fwd_vld,
   output logic              fwd_val,
   output logic [COMP_W-1:0] col_r,
   output logic [COMP_W-1:0] col_g,
   output logic [COMP_W-1:0] col_b,
   output logic [COMP_W-1:0] col_w
);
   localparam int unsigned WB = word_bits(COMP_W, WHITE_EN);
   localparam int unsigned CW = $clog2(WB + 1);

   logic [WB-1:0] shadow;
   logic [CW-1:0] cnt;
   logic          full;
   logic [COMP_W-1:0] nx_r, nx_g, nx_b, nx_w;

   assign full = (cnt == CW'(WB));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow  <= '0;
         cnt     <= '0;
         fwd_vld <= 1'b0;
         fwd_val <= 1'b0;
      end else begin
         fwd_vld <= bit_vld & full;
         fwd_val <= bit_val;
         if (line_rst) begin
            cnt <= '0;
         end else if (bit_vld && !full) begin
            shadow <= {shadow[WB-2:0], bit_val};
            cnt    <= cnt + CW'(1);
         end
      end
   end

   // Field layout per variant
   generate
      if (WHITE_EN) begin : g_rgbw
         assign nx_r = shadow[4*COMP_W-1:3*COMP_W];
         assign nx_g = shadow[3*COMP_W-1:2*COMP_W];
         assign nx_b = shadow[2*COMP_W-1:COMP_W];
         assign nx_w = shadow[COMP_W-1:0];
      end else begin : g_grb
         assign nx_g = shadow[3*COMP_W-1:2*COMP_W];
         assign nx_r = shadow[2*COMP_W-1:COMP_W];
         assign nx_b = shadow[COMP_W-1:0];
         assign nx_w = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_r <= '0;
         col_g <= '0;
         col_b <= '0;
         col_w <= '0;
      end else if (line_rst && full) begin
         col_r <= nx_r;
         col_g <= nx_g;
         col_b <= nx_b;
         col_w <= nx_w;
      end
   end

   assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(WB));
   assert_colour_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_rst |=> ($stable(col_r) && $stable(col_g) && $stable(col_b) && $stable(col_w)));
   assert_partial_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rst && !full) |=> $stable(col_g));
endmodule

// File: rtl/pxn_bit_regen.sv
module pxn_bit_regen #(
   parameter int unsigned T0H_CYC = 7,
   parameter int unsigned T1H_CYC = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fwd_vld,
   input  logic fwd_val,
   output logic dout
);
   localparam int unsigned TW = $clog2(T1H_CYC + 1);

   logic [TW-1:0] tcnt;
   logic [TW-1:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout   <= 1'b0;
         tcnt   <= '0;
         hi_len <= '0;
      end else if (fwd_vld) begin
         dout   <= 1'b1;
         tcnt   <= TW'(1);
         hi_len <= fwd_val ? TW'(T1H_CYC) : TW'(T0H_CYC);
      end else if (dout) begin
         if (tcnt == hi_len) dout <= 1'b0;
         else                tcnt <= tcnt + TW'(1);
      end
   end

   assert_pulse_from_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout) |-> $past(fwd_vld));
   assert_pulse_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dout |-> (tcnt <= TW'(T1H_CYC)));
endmodule

// File: rtl/pixel_chain_node.sv
module pixel_chain_node
   import pixel_chain_pkg::*;
#(
   parameter int unsigned COMP_W     = 8,
   parameter bit          WHITE_EN   = 1'b0,
   parameter int unsigned SAMPLE_CYC = 11,
   parameter int unsigned RESET_CYC  = 1000,
   parameter int unsigned T0H_CYC    = 7,
   parameter int unsigned T1H_CYC    = 14,
   parameter int unsigned SYNC_STG   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   output logic              dout,
   output logic [COMP_W-1:0] col_r,
   output logic [COMP_W-1:0] col_g,
   output logic [COMP_W-1:0] col_b,
   output logic [COMP_W-1:0] col_w
);
   logic bit_vld, bit_val, line_rst, fwd_vld, fwd_val;

   initial begin
      assert (COMP_W >= 1) else $error("COMP_W must be positive");
      assert (SYNC_STG >= 2) else $error("SYNC_STG must be at least 2");
      assert (T0H_CYC >= 1 && T0H_CYC < T1H_CYC) else $error("bad pulse widths");
      assert (SAMPLE_CYC > 1) else $error("SAMPLE_CYC too small");
      assert (RESET_CYC > SAMPLE_CYC + T1H_CYC) else $error("RESET_CYC too short");
   end

   pxn_bit_slicer #(
      .SAMPLE_CYC(SAMPLE_CYC), .RESET_CYC(RESET_CYC), .SYNC_STG(SYNC_STG)
   ) u_slicer (
      .clk(clk), .rst_n(rst_n), .din(din),
      .bit_vld(bit_vld), .bit_val(bit_val), .line_rst(line_rst)
   );

   pxn_word_capture #(
      .COMP_W(COMP_W), .WHITE_EN(WHITE_EN)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
      .line_rst(line_rst), .fwd_vld(fwd_vld), .fwd_val(fwd_val),
      .col_r(col_r), .col_g(col_g), .col_b(col_b), .col_w(col_w)
   );

   pxn_bit_regen #(
      .T0H_CYC(T0H_CYC), .T1H_CYC(T1H_CYC)
   ) u_regen (
      .clk(clk), .rst_n(rst_n), .fwd_vld(fwd_vld), .fwd_val(fwd_val), .dout(dout)
   );
endmodule

// File: tb/pixel_chain_node_tb.sv
module pixel_chain_node_tb_top;
   localparam int CLK_NS   = 50;
   localparam int RST_CYC  = 1000;
   localparam int T0H      = 7;
   localparam int T1H      = 14;
   localparam int CELL     = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0, din_w = 1'b0;
   logic dout, dout_w;
   logic [7:0] cr, cg, cb, cw, wr, wg, wbl, ww;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   pixel_chain_node #(.RESET_CYC(RST_CYC), .T0H_CYC(T0H), .T1H_CYC(T1H)) dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
      .col_r(cr), .col_g(cg), .col_b(cb), .col_w(cw));

   pixel_chain_node #(.WHITE_EN(1'b1), .RESET_CYC(RST_CYC), .T0H_CYC(T0H), .T1H_CYC(T1H)) dut_w_i (
      .clk(clk), .rst_n(rst_n), .din(din_w), .dout(dout_w),
      .col_r(wr), .col_g(wg), .col_b(wbl), .col_w(ww));

   // Forwarded-bit monitors
   logic fwd_bits [0:255];
   int fwd_cnt = 0, wid = 0, bad_wid = 0;
   int fwd_cnt_w = 0, wid_w = 0;

   always @(negedge clk) begin
      if (dout) wid++;
      else if (wid > 0) begin
         if (wid == T1H) fwd_bits[fwd_cnt % 256] = 1'b1;
         else if (wid == T0H) fwd_bits[fwd_cnt % 256] = 1'b0;
         else bad_wid++;
         fwd_cnt++;
         wid = 0;
      end
      if (dout_w) wid_w++;
      else if (wid_w > 0) begin
         fwd_cnt_w++;
         wid_w = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit v, input bit sel, input int hi0, input int hi1);
      int hi = v ? hi1 : hi0;
      if (sel) din_w = 1'b1; else din = 1'b1;
      cyc(hi);
      if (sel) din_w = 1'b0; else din = 1'b0;
      cyc(CELL - hi);
   endtask

   task automatic send_word(input logic [31:0] w, input int n, input bit sel,
                            input int hi0, input int hi1);
      for (int i = n - 1; i >= 0; i--) send_bit(w[i], sel, hi0, hi1);
   endtask

   task automatic line_reset();
      din = 1'b0; din_w = 1'b0;
      cyc(RST_CYC + 30);
   endtask

   task automatic clear_mon();
      fwd_cnt = 0; bad_wid = 0; fwd_cnt_w = 0;
   endtask

   task automatic t_reset_state();
      chk(cr == 8'h0 && cg == 8'h0, "R1 red/green after reset", {cr, cg}, 0);
      chk(cb == 8'h0 && cw == 8'h0, "R1 blue/white after reset", {cb, cw}, 0);
      chk(dout == 1'b0, "R1 dout low after reset", dout, 0);
   endtask

   task automatic t_single_pixel();
      clear_mon();
      send_word(32'h12A53C, 24, 1'b0, T0H, T1H);
      cyc(20);
      chk(cr == 0 && cg == 0 && cb == 0, "R3 no commit before line reset", {cr, cg, cb}, 0);
      line_reset();
      chk(cr == 8'hA5, "R2 red field", cr, 8'hA5);
      chk(cg == 8'h12, "R2 green field", cg, 8'h12);
      chk(cb == 8'h3C, "R2 blue field", cb, 8'h3C);
      chk(fwd_cnt == 0, "R4 first word not forwarded", fwd_cnt, 0);
   endtask

   task automatic t_chain();
      logic [47:0] tail = 48'hF0_0F_81_7E_C3_55;
      bit ok = 1'b1;
      clear_mon();
      send_word(32'h336699, 24, 1'b0, T0H, T1H);
      send_word(tail[47:24], 24, 1'b0, T0H, T1H);
      send_word(tail[23:0], 24, 1'b0, T0H, T1H);
      line_reset();
      chk({cg, cr, cb} == 24'h336699, "R8 second frame captured", {cg, cr, cb}, 24'h336699);
      chk(fwd_cnt == 48, "R4 excess bit count", fwd_cnt, 48);
      for (int i = 0; i < 48; i++) if (fwd_bits[i] != tail[47 - i]) ok = 1'b0;
      chk(ok, "R4 forwarded bit order", ok, 1);
      chk(bad_wid == 0, "R5 regenerated pulse widths", bad_wid, 0);
   endtask

   task automatic t_gap();
      clear_mon();
      send_word(32'hC7, 8, 1'b0, T0H, T1H);
      din = 1'b0;
      cyc(RST_CYC / 2);
      send_word(32'h1E42, 16, 1'b0, T0H, T1H);
      cyc(20);
      chk({cg, cr, cb} == 24'h336699, "R3 short gap keeps colour", {cg, cr, cb}, 24'h336699);
      line_reset();
      chk({cg, cr, cb} == 24'hC71E42, "R3 word across gap", {cg, cr, cb}, 24'hC71E42);
   endtask

   task automatic t_threshold();
      clear_mon();
      // highs of 9 (before sample point) decode 0, 13 decode 1
      send_word(32'h5AF00F, 24, 1'b0, 9, 13);
      send_word(32'h96, 8, 1'b0, 9, 13);
      line_reset();
      chk({cg, cr, cb} == 24'h5AF00F, "R6 sample point decision", {cg, cr, cb}, 24'h5AF00F);
      chk(fwd_cnt == 8 && bad_wid == 0, "R5 widths from marginal input", fwd_cnt, 8);
   endtask

   task automatic t_partial();
      clear_mon();
      send_word(32'h3FF, 10, 1'b0, T0H, T1H);
      line_reset();
      chk({cg, cr, cb} == 24'h5AF00F, "R7 partial word ignored", {cg, cr, cb}, 24'h5AF00F);
      send_word(32'h010203, 24, 1'b0, T0H, T1H);
      send_word(32'h1, 1, 1'b0, T0H, T1H);
      line_reset();
      chk({cg, cr, cb} == 24'h010203, "R8 capture re-armed", {cg, cr, cb}, 24'h010203);
      chk(fwd_cnt == 1 && fwd_bits[0] == 1'b1, "R8 forwarding after first word", fwd_cnt, 1);
   endtask

   task automatic t_rgbw();
      clear_mon();
      send_word(32'hDE_AD_BE_EF, 32, 1'b1, T0H, T1H);
      send_word(32'hA5, 8, 1'b1, T0H, T1H);
      line_reset();
      chk(wr == 8'hDE && wg == 8'hAD, "R9 red/green fields", {wr, wg}, 16'hDEAD);
      chk(wbl == 8'hBE && ww == 8'hEF, "R9 blue/white fields", {wbl, ww}, 16'hBEEF);
      chk(fwd_cnt_w == 8, "R9 excess bits forwarded", fwd_cnt_w, 8);
      chk(cw == 8'h0, "R2 white output stays 0 in three-component variant", cw, 0);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cyc(5);
      t_reset_state();
      rst_n = 1'b1;
      line_reset();
      t_single_pixel();
      t_chain();
      t_gap();
      t_threshold();
      t_partial();
      t_rgbw();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule